// File: doc/BRIEF.md
# Return Stack with Carry Preservation

This block is the hardware return stack of a small 4-bit processor core. Every entry packs the carry flag and a 12-bit return address into one 13-bit word, with the carry in the most significant bit. A subroutine call or an accepted interrupt pushes the address it will later come back to, together with the current carry. A return pops the newest entry and hands its address back to the sequencer. There are two kinds of return. An interrupt-style return also brings back the saved carry. A table-constant return leaves the carry as it was.

The stack is a shift register, so the newest entry always sits at position 0. The core can read that entry at any time from the peek outputs. When the core pushes onto a full stack, the oldest entry drops off the bottom and the push is never refused; a one-cycle overflow pulse marks the lost entry. A return on an empty stack still yields a word: the content left at the top by earlier shifts. It also raises a one-cycle underflow pulse. Interrupt arbitration lies outside this block.

Top module: `carry_call_stack`

## Requirements
- R1: While rst_n is low and in the first cycle after it, the depth is 0, the peek address, peek carry, return address and carry outputs are 0, and both status pulses are low.
- R2: A push stores the word {cy_i, pc_i} (carry in bit 12, address in bits 11:0) at the top. In the cycle after the push, peek_pc_o and peek_cy_o show that word and the depth has risen by one.
- R3: Pops return entries in last-in, first-out order. After a pop, the peek outputs show the entry that was second from the top.
- R4: A pop with restore_cy_i high loads ret_pc_o with the popped address and cy_o with the popped carry. Both are visible in the cycle after the pop.
- R5: A pop with restore_cy_i low loads ret_pc_o with the popped address and leaves cy_o unchanged.
- R6: A push at depth 4 shifts out the oldest entry, keeps the depth at 4 and drives overflow_o high for the next cycle only. The depth never exceeds 4.
- R7: A pop at depth 0 still returns the top word, keeps the depth at 0 and drives underflow_o high for the next cycle only. On every pop the bottom position keeps its own value, so over time the stack fills with copies of the last word shifted in.
- R8: When push_i and pop_i are high in the same cycle, only the push takes effect. ret_pc_o, cy_o and underflow_o are not affected by the pop.
- R9: overflow_o and underflow_o stay low in every cycle that does not follow a qualifying push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| pop_i | input | 1 | Pop strobe (either kind of return) |
| restore_cy_i | input | 1 | With pop_i: 1 restores carry from the entry, 0 keeps it |
| pc_i | input | 12 | Return address to push |
| cy_i | input | 1 | Carry flag to push |
| peek_pc_o | output | 12 | Address field of the top entry |
| peek_cy_o | output | 1 | Carry field of the top entry |
| ret_pc_o | output | 12 | Address taken by the last pop |
| cy_o | output | 1 | Carry as restored by the stack |
| depth_o | output | 3 | Number of valid entries, 0 to 4 |
| overflow_o | output | 1 | One-cycle pulse after a push at full depth |
| underflow_o | output | 1 | One-cycle pulse after a pop at empty depth |

## Verification
The assertions require only that the strobes are known after reset; they allow push and pop in the same cycle and check that the push wins. The stimulus is weighted random. It leans towards pushes in some phases and towards pops in others, so the stack is driven through full and empty depth repeatedly. Directed sequences cover a fifth push, pops past empty, both return kinds, and simultaneous strobes.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int unsigned STK_DEPTH = 4;
  localparam int unsigned PC_W      = 12;
  localparam int unsigned ENT_W     = PC_W + 1;
  localparam int unsigned CNT_W     = $clog2(STK_DEPTH + 1);

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/ccs_shift_store.sv
module ccs_shift_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned EW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_push_i,
  input  logic          do_pop_i,
  input  logic [EW-1:0] din_i,
  output logic [EW-1:0] top_o
);
  logic [EW-1:0] ent_q [DEPTH];
  logic [EW-1:0] ent_d [DEPTH];
  logic          shift_en;

  assign shift_en = do_push_i | do_pop_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      ent_d[i] = ent_q[i];
      if (do_push_i) begin
        if (i == 0) ent_d[i] = din_i;
        else        ent_d[i] = ent_q[(i == 0) ? 0 : i - 1];
      end else if (do_pop_i) begin
        if (i == DEPTH - 1) ent_d[i] = ent_q[i];
        else                ent_d[i] = ent_q[(i == DEPTH - 1) ? i : i + 1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ent_q[i] <= '0;
      else if (shift_en) ent_q[i] <= ent_d[i];
    end
  end

  assign top_o = ent_q[0];

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    do_push_i |=> ent_q[0] == $past(din_i)); // R2
  AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop_i && !do_push_i |=> ent_q[0] == $past(ent_q[1])); // R3
  AST_BOTTOM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop_i && !do_push_i |=> $stable(ent_q[DEPTH-1])); // R7
endmodule

// File: rtl/ccs_depth_ctr.sv
module ccs_depth_ctr #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_push_i,
  input  logic          do_pop_i,
  output logic [CW-1:0] depth_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] depth_q, depth_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          full, empty;

  assign full  = (depth_q == FULL);
  assign empty = (depth_q == '0);

  always_comb begin
    depth_d = depth_q;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    if (do_push_i) begin
      if (full) ovf_d   = 1'b1;
      else      depth_d = depth_q + 1'b1;
    end else if (do_pop_i) begin
      if (empty) unf_d   = 1'b1;
      else       depth_d = depth_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  assign depth_o = depth_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= FULL); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(do_push_i) && $past(depth_q) == FULL && depth_q == FULL); // R6
  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> $past(do_pop_i) && !$past(do_push_i) && depth_q == '0); // R7
  AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_q && unf_q)); // R9
endmodule

// File: rtl/ccs_ret_port.sv
module ccs_ret_port #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_pop_i,
  input  logic          restore_i,
  input  logic [AW:0]   top_i,
  output logic [AW-1:0] ret_pc_o,
  output logic          cy_o
);
  logic [AW-1:0] ret_pc_q;
  logic          cy_q;
  logic          cy_en;

  assign cy_en = do_pop_i & restore_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ret_pc_q <= '0;
    else if (do_pop_i) ret_pc_q <= top_i[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cy_q <= 1'b0;
    else if (cy_en) cy_q <= top_i[AW];
  end

  assign ret_pc_o = ret_pc_q;
  assign cy_o     = cy_q;

  AST_CY_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop_i && restore_i |=> cy_q == $past(top_i[AW])); // R4
  AST_CY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_pop_i && restore_i) |=> $stable(cy_q)); // R5
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop_i |=> ret_pc_q == $past(top_i[AW-1:0])); // R4
endmodule

// File: rtl/carry_call_stack.sv
module carry_call_stack
  import ccs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_i,
  input  logic                   pop_i,
  input  logic                   restore_cy_i,
  input  logic [PC_W-1:0]        pc_i,
  input  logic                   cy_i,
  output logic [PC_W-1:0]        peek_pc_o,
  output logic                   peek_cy_o,
  output logic [PC_W-1:0]        ret_pc_o,
  output logic                   cy_o,
  output logic [CNT_W-1:0]       depth_o,
  output logic                   overflow_o,
  output logic                   underflow_o
);
  stk_op_e          op;
  logic             do_push, do_pop;
  logic [ENT_W-1:0] top_word;

  always_comb begin
    if (push_i)     op = OP_PUSH;
    else if (pop_i) op = OP_POP;
    else            op = OP_IDLE;
  end

  assign do_push = (op == OP_PUSH);
  assign do_pop  = (op == OP_POP);

  ccs_shift_store #(.DEPTH(STK_DEPTH), .EW(ENT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_push_i (do_push),
    .do_pop_i  (do_pop),
    .din_i     ({cy_i, pc_i}),
    .top_o     (top_word)
  );

  ccs_depth_ctr #(.DEPTH(STK_DEPTH), .CW(CNT_W)) u_depth (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_push_i (do_push),
    .do_pop_i  (do_pop),
    .depth_o   (depth_o),
    .ovf_o     (overflow_o),
    .unf_o     (underflow_o)
  );

  ccs_ret_port #(.AW(PC_W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_pop_i  (do_pop),
    .restore_i (restore_cy_i),
    .top_i     (top_word),
    .ret_pc_o  (ret_pc_o),
    .cy_o      (cy_o)
  );

  assign peek_pc_o = top_word[PC_W-1:0];
  assign peek_cy_o = top_word[ENT_W-1];

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i |=> $stable(ret_pc_o) && $stable(cy_o) && !underflow_o); // R8
  AST_PUSH_PEEK: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> peek_pc_o == $past(pc_i) && peek_cy_o == $past(cy_i)); // R2
endmodule

// File: tb/carry_call_stack_tb_top.sv
module carry_call_stack_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_i, pop_i, restore_cy_i, cy_i;
  logic [11:0] pc_i;
  logic [11:0] peek_pc_o, ret_pc_o;
  logic        peek_cy_o, cy_o, overflow_o, underflow_o;
  logic [2:0]  depth_o;

  int checks = 0;
  int errors = 0;

  logic [12:0] m_stk [DEPTH];
  int          m_depth;
  logic [11:0] m_ret;
  logic        m_cy, m_ovf, m_unf;
  string       tag_top, tag_ret, tag_cy;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_call_stack dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .restore_cy_i(restore_cy_i), .pc_i(pc_i), .cy_i(cy_i),
    .peek_pc_o(peek_pc_o), .peek_cy_o(peek_cy_o), .ret_pc_o(ret_pc_o),
    .cy_o(cy_o), .depth_o(depth_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_depth_after_push(int d);
    return (d == DEPTH) ? DEPTH : d + 1;
  endfunction

  task automatic compare_all();
    chk(tag_top, "peek_pc", int'(peek_pc_o), int'(m_stk[0][11:0]));
    chk(tag_top, "peek_cy", int'(peek_cy_o), int'(m_stk[0][12]));
    chk("R6", "depth", int'(depth_o), m_depth);
    chk(tag_ret, "ret_pc", int'(ret_pc_o), int'(m_ret));
    chk(tag_cy, "cy", int'(cy_o), int'(m_cy));
    chk(m_ovf ? "R6" : "R9", "overflow", int'(overflow_o), int'(m_ovf));
    chk(m_unf ? "R7" : "R9", "underflow", int'(underflow_o), int'(m_unf));
  endtask

  // drive at negedge, model what the next posedge produces, compare at the next negedge
  task automatic step(bit p, bit q, bit r, logic [11:0] a, bit c);
    push_i = p; pop_i = q; restore_cy_i = r; pc_i = a; cy_i = c;
    m_ovf = 1'b0; m_unf = 1'b0;
    tag_top = "R2"; tag_ret = "R4"; tag_cy = "R5";
    if (p) begin
      m_ovf = (m_depth == DEPTH);
      for (int i = DEPTH - 1; i > 0; i--) m_stk[i] = m_stk[i-1];
      m_stk[0] = {c, a};
      m_depth = exp_depth_after_push(m_depth);
      if (q) begin tag_ret = "R8"; tag_cy = "R8"; end
    end else if (q) begin
      m_unf = (m_depth == 0);
      m_ret = m_stk[0][11:0];
      if (r) begin m_cy = m_stk[0][12]; tag_cy = "R4"; end
      for (int i = 0; i < DEPTH - 1; i++) m_stk[i] = m_stk[i+1];
      if (m_depth > 0) m_depth--;
      tag_top = m_unf ? "R7" : "R3";
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; push_i = 0; pop_i = 0; restore_cy_i = 0; pc_i = '0; cy_i = 0;
    for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
    m_depth = 0; m_ret = '0; m_cy = 0; m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk);
    tag_top = "R1"; tag_ret = "R1"; tag_cy = "R1";
    compare_all();
    chk("R1", "depth reset", int'(depth_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // directed: five pushes, overflow on the fifth
    for (int i = 0; i < 5; i++) step(1, 0, 0, 12'h100 + 12'(i), i[0]);
    // pops past empty, mixed restore kinds
    for (int i = 0; i < 6; i++) step(0, 1, i[0], '0, 0);
    // idle cycles: flags low
    step(0, 0, 0, 12'hABC, 1);
    step(0, 0, 1, 12'h123, 0);
    // simultaneous strobes
    step(1, 0, 0, 12'hFFF, 1);
    step(1, 1, 1, 12'h555, 0);
    step(0, 1, 0, '0, 0);
    step(0, 1, 1, '0, 0);

    // random phases: push-heavy, pop-heavy, balanced
    for (int ph = 0; ph < 12; ph++) begin
      for (int n = 0; n < 60; n++) begin
        int unsigned roll;
        bit p, q;
        roll = $urandom_range(99);
        case (ph % 3)
          0: begin p = roll < 60; q = roll >= 50; end
          1: begin p = roll < 25; q = roll >= 20; end
          default: begin p = roll < 40; q = roll >= 55; end
        endcase
        step(p, q, 1'($urandom_range(1)), 12'($urandom), 1'($urandom_range(1)));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule